// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block turns the two phase signals of an incremental encoder into a wrapping position count. Both phases are first brought into the clock domain through two-flop synchronizers, and edges are found on the synchronized values. A two-bit mode input picks which edges advance the count: edges of phase A only, edges of phase B only, or edges of both phases. The first two give two counts per encoder cycle. The third gives four counts per cycle, so one count is a quarter of an encoder period.

The count direction comes only from the phase relationship, and the block reports it on a status output. While an encoder mode is selected, a direction write from software has no effect. The count runs between zero and a limit value given on an input. That limit is used directly, with no shadow register, so a new value applies to the very next count. Each wrap, in either direction, raises a one-cycle flag.

Top module: `qdec_counter`

## Requirements
- R1: After a synchronous reset, `pos_count` is 0, `dir_down` is 0 (counting up) and `wrap_pulse` is 0.
- R2: With `mode` = 3, every edge of either phase changes the count by one, so one full encoder cycle moves the count by four.
- R3: With `mode` = 1, only edges of phase A change the count. With `mode` = 2, only edges of phase B change it. Either way, one full encoder cycle moves the count by two.
- R4: When A leads B (sequence 00, 10, 11, 01 for A,B) the count goes up and `dir_down` is 0. When B leads A, the count goes down and `dir_down` is 1. On a counted edge of A, the move is up when A differs from B after the edge. On a counted edge of B, the move is up when B equals A after the edge.
- R5: An up count from a value at or above `reload_val` gives 0, with `wrap_pulse` high for exactly one cycle.
- R6: A down count from 0 gives `reload_val`, with `wrap_pulse` high for exactly one cycle.
- R7: If both synchronized phases change in the same cycle, the count and the direction stay as they were.
- R8: With `mode` = 0, no phase edge is counted, and a cycle with `dir_we` high loads `dir_wval` into `dir_down`. With `mode` = 1, 2 or 3, `dir_we` has no effect on `dir_down`.
- R9: A phase change is applied at the inputs between clock edges. It is not visible after the second rising edge that follows. It shows on `pos_count`, `dir_down` and `wrap_pulse` after the third rising edge.
- R10: `reload_val` is used without buffering: a value changed between counts governs the very next wrap decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| phase_a | input | 1 | Encoder phase A, asynchronous |
| phase_b | input | 1 | Encoder phase B, asynchronous |
| mode | input | 2 | 0 idle, 1 count A edges, 2 count B edges, 3 count both |
| reload_val | input | CNT_W | Wrap limit of the count |
| dir_we | input | 1 | Software direction write strobe |
| dir_wval | input | 1 | Software direction value (1 = down) |
| pos_count | output | CNT_W | Position count |
| dir_down | output | 1 | Direction status, 1 when counting down |
| wrap_pulse | output | 1 | One-cycle flag on wrap in either direction |

## Verification
The phases are driven through full forward and reverse quadrature cycles in each mode. The forward and reverse cycles separate the x4 step counts from the x2 step counts, and show which channel's edges are actually counted and which way they move the count. Single steps across zero and across the limit exercise both wrap paths. A limit lowered below the current count shows that the limit is used unbuffered. Simultaneous changes of both phases, software direction writes in idle and in encoder modes, and a sample taken one edge early cover the refused transitions, the direction lock and the pipeline latency.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

    typedef enum logic [1:0] {
        QM_IDLE = 2'd0,
        QM_CH_A = 2'd1,
        QM_CH_B = 2'd2,
        QM_BOTH = 2'd3
    } qmode_e;

    typedef struct packed {
        logic step;
        logic down;
    } qstep_t;

    // Decide whether this cycle's phase change counts, and which way.
    function automatic qstep_t decode_step(qmode_e m, logic a_now, logic a_old,
                                           logic b_now, logic b_old);
        qstep_t r;
        logic ae, be, use_a, use_b;
        ae    = a_now ^ a_old;
        be    = b_now ^ b_old;
        use_a = ae && !be && (m == QM_CH_A || m == QM_BOTH);
        use_b = be && !ae && (m == QM_CH_B || m == QM_BOTH);
        r.step = use_a | use_b;
        r.down = use_a ? (a_now == b_now) : (b_now != a_now);
        return r;
    endfunction

endpackage

// File: rtl/qdec_sync.sv
module qdec_sync #(
    parameter int N      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);
    localparam int LAST = STAGES - 1;

    for (genvar i = 0; i < N; i++) begin : g_ch
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '0;
            else     chain <= {chain[STAGES-2:0], din[i]};
        end
        assign dout[i] = chain[LAST];
    end
endmodule

// File: rtl/qdec_edge.sv
module qdec_edge
    import qdec_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   a_s,
    input  logic   b_s,
    input  qmode_e mode,
    output qstep_t st,
    output logic   skew
);
    logic a_d, b_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_d <= 1'b0;
            b_d <= 1'b0;
        end else begin
            a_d <= a_s;
            b_d <= b_s;
        end
    end

    always_comb begin
        st   = decode_step(mode, a_s, a_d, b_s, b_d);
        skew = (a_s ^ a_d) && (b_s ^ b_d);
    end

    AST_IDLE_NO_STEP: assert property (@(posedge clk) disable iff (rst)
        (mode == QM_IDLE) |-> !st.step); // R8
endmodule

// File: rtl/qdec_count.sv
module qdec_count
    import qdec_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  qstep_t           st,
    input  qmode_e           mode,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             dir_we,
    input  logic             dir_wval,
    output logic [CNT_W-1:0] cnt_o,
    output logic             down_o,
    output logic             wrap_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             down_q, wrap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            down_q <= 1'b0;
            wrap_q <= 1'b0;
        end else begin
            wrap_q <= 1'b0;
            if (st.step) begin
                down_q <= st.down;
                if (!st.down) begin
                    if (cnt_q >= reload_val) begin
                        cnt_q  <= '0;
                        wrap_q <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + ONE;
                    end
                end else if (cnt_q == '0) begin
                    cnt_q  <= reload_val;
                    wrap_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - ONE;
                end
            end else if (mode == QM_IDLE && dir_we) begin
                down_q <= dir_wval;
            end
        end
    end

    assign cnt_o  = cnt_q;
    assign down_o = down_q;
    assign wrap_o = wrap_q;

    AST_UP_WRAP: assert property (@(posedge clk) disable iff (rst)
        (st.step && !st.down && cnt_q >= reload_val) |=> (cnt_q == '0 && wrap_q)); // R5
    AST_DOWN_WRAP: assert property (@(posedge clk) disable iff (rst)
        (st.step && st.down && cnt_q == '0) |=> (cnt_q == $past(reload_val) && wrap_q)); // R6
    AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (rst)
        !st.step |=> ($stable(cnt_q) && !wrap_q)); // R2
    AST_DIR_LOCK: assert property (@(posedge clk) disable iff (rst)
        (mode != QM_IDLE && dir_we && !st.step) |=> $stable(down_q)); // R8
endmodule

// File: rtl/qdec_counter.sv
module qdec_counter
    import qdec_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             phase_a,
    input  logic             phase_b,
    input  logic [1:0]       mode,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             dir_we,
    input  logic             dir_wval,
    output logic [CNT_W-1:0] pos_count,
    output logic             dir_down,
    output logic             wrap_pulse
);
    logic [1:0] ph_s;
    qstep_t     st;
    logic       skew;
    qmode_e     mode_e;

    assign mode_e = qmode_e'(mode);

    qdec_sync #(.N(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .din ({phase_b, phase_a}),
        .dout(ph_s)
    );

    qdec_edge u_edge (
        .clk (clk),
        .rst (rst),
        .a_s (ph_s[0]),
        .b_s (ph_s[1]),
        .mode(mode_e),
        .st  (st),
        .skew(skew)
    );

    qdec_count #(.CNT_W(CNT_W)) u_count (
        .clk       (clk),
        .rst       (rst),
        .st        (st),
        .mode      (mode_e),
        .reload_val(reload_val),
        .dir_we    (dir_we),
        .dir_wval  (dir_wval),
        .cnt_o     (pos_count),
        .down_o    (dir_down),
        .wrap_o    (wrap_pulse)
    );

    AST_SKEW_IGNORED: assert property (@(posedge clk) disable iff (rst)
        skew |=> ($stable(pos_count) && $stable(dir_down))); // R7
endmodule

// File: tb/qdec_counter_test.sv
`timescale 1ns/1ps
module qdec_counter_test;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         phase_a = 1'b0, phase_b = 1'b0;
    logic [1:0]   mode = 2'd0;
    logic [W-1:0] reload_val = 8'd10;
    logic         dir_we = 1'b0, dir_wval = 1'b0;
    logic [W-1:0] pos_count;
    logic         dir_down, wrap_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    qdec_counter #(.CNT_W(W)) uut (
        .clk(clk), .rst(rst), .phase_a(phase_a), .phase_b(phase_b),
        .mode(mode), .reload_val(reload_val), .dir_we(dir_we), .dir_wval(dir_wval),
        .pos_count(pos_count), .dir_down(dir_down), .wrap_pulse(wrap_pulse)
    );

    typedef struct {
        int    prev_cnt;
        int    cnt;
        int    dn;
        int    wr;
        string req;
    } item_t;

    item_t q[$];
    event  go;

    int exp_cnt = 0, exp_dn = 0;
    logic pa = 1'b0, pb = 1'b0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver: model the step, queue the expectation, apply the phases.
    task automatic drive(input logic na, input logic nb, input string req);
        item_t it;
        logic achg, bchg, counted, up;
        achg = (na != pa);
        bchg = (nb != pb);
        counted = 1'b0;
        if (!(achg && bchg)) begin
            case (mode)
                2'd1: counted = achg;
                2'd2: counted = bchg;
                2'd3: counted = achg || bchg;
                default: counted = 1'b0;
            endcase
        end
        up = achg ? (na != nb) : (nb == na);
        it.prev_cnt = exp_cnt;
        it.wr = 0;
        if (counted) begin
            exp_dn = up ? 0 : 1;
            if (up) begin
                if (exp_cnt >= int'(reload_val)) begin exp_cnt = 0; it.wr = 1; end
                else exp_cnt = exp_cnt + 1;
            end else begin
                if (exp_cnt == 0) begin exp_cnt = int'(reload_val); it.wr = 1; end
                else exp_cnt = exp_cnt - 1;
            end
        end
        it.cnt = exp_cnt;
        it.dn  = exp_dn;
        it.req = req;
        pa = na;
        pb = nb;
        @(negedge clk);
        phase_a = na;
        phase_b = nb;
        q.push_back(it);
        ->go;
        repeat (5) @(posedge clk);
    endtask

    // Monitor: pop and compare as results emerge.
    initial begin
        forever begin
            item_t it;
            @(go);
            it = q.pop_front();
            repeat (2) @(posedge clk);
            #1 chk("R9 count before third edge", int'(pos_count), it.prev_cnt);
            @(posedge clk);
            #1;
            chk({it.req, " count"}, int'(pos_count), it.cnt);
            chk({it.req, " direction"}, int'(dir_down), it.dn);
            chk({it.req, " wrap flag"}, int'(wrap_pulse), it.wr);
            @(posedge clk);
            #1 chk("R5/R6 wrap flag one cycle", int'(wrap_pulse), 0);
        end
    end

    task automatic up_cycle(input string req);
        drive(1'b1, 1'b0, req);
        drive(1'b1, 1'b1, req);
        drive(1'b0, 1'b1, req);
        drive(1'b0, 1'b0, req);
    endtask

    task automatic down_cycle(input string req);
        drive(1'b0, 1'b1, req);
        drive(1'b1, 1'b1, req);
        drive(1'b1, 1'b0, req);
        drive(1'b0, 1'b0, req);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 reset count", int'(pos_count), 0);
        chk("R1 reset direction", int'(dir_down), 0);
        chk("R1 reset wrap", int'(wrap_pulse), 0);

        @(negedge clk) mode = 2'd3;
        up_cycle("R2 R4 x4 forward");
        down_cycle("R2 R4 x4 reverse");
        drive(1'b0, 1'b1, "R6 down wrap");
        drive(1'b0, 1'b0, "R5 up wrap");

        @(negedge clk) mode = 2'd1;
        up_cycle("R3 A-only forward");
        @(negedge clk) mode = 2'd2;
        down_cycle("R3 B-only reverse");

        @(negedge clk) mode = 2'd3;
        drive(1'b1, 1'b1, "R7 both phases change");
        drive(1'b0, 1'b0, "R7 both phases change back");

        // Direction written in idle mode loads.
        @(negedge clk) begin mode = 2'd0; dir_we = 1'b1; dir_wval = 1'b0; end
        @(posedge clk) #1 chk("R8 idle direction write", int'(dir_down), 0);
        exp_dn = 0;
        @(negedge clk) dir_we = 1'b0;
        drive(1'b0, 1'b1, "R8 idle no count");

        // Direction written in encoder mode is ignored.
        @(negedge clk) begin mode = 2'd3; dir_we = 1'b1; dir_wval = 1'b1; end
        @(posedge clk) #1 chk("R8 encoder mode write ignored", int'(dir_down), 0);
        @(negedge clk) dir_we = 1'b0;
        @(posedge clk) #1 chk("R8 direction after ignored write", int'(dir_down), 0);

        drive(1'b0, 1'b0, "R4 forward from 01");
        drive(1'b1, 1'b0, "R4 forward");
        drive(1'b1, 1'b1, "R4 forward");
        drive(1'b0, 1'b1, "R4 forward");
        drive(1'b0, 1'b0, "R4 forward");

        @(negedge clk) reload_val = 8'd3;
        drive(1'b1, 1'b0, "R10 lowered limit wraps");
        drive(1'b1, 1'b1, "R10 count after limit change");

        repeat (4) @(posedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule